// File: doc/BRIEF.md
# Three-Channel Edge Capture Unit with Two-Entry FIFOs

This block timestamps signal transitions. It has three capture pins. Each pin is synchronised to the system clock and then qualified. A qualified edge of the selected kind makes the channel store the current value of an externally supplied free-running timebase. The value goes into the channel's own two-entry FIFO.

Software, or a neighbouring block, reads a channel through a pop strobe. The oldest stored value is always visible on that channel's read port, and the pop strobe discards it. Each channel reports how many entries it holds. Each channel has an event flag that is set on every stored capture and cleared by a write-1 strobe. Each channel also has an interrupt line, which is gated by a per-channel mask.

Top module: `edge_capture_unit`

## Requirements
- R1: A pin level counts only after the synchronised level has been sampled unchanged on two consecutive clock edges. A pulse that lasts one clock cycle is never captured, and a pulse that lasts two cycles is captured.
- R2: Each channel has a 2-bit edge select at `edge_sel[2k+1:2k]`. The codes are: 00 = no capture, 01 = rising edges only, 10 = falling edges only, 11 = both edges.
- R3: A capture stores the value of `tbase` that is present on the clock edge where the qualified edge is accepted.
- R4: Each channel holds up to two entries. The fill level is reported as 0, 1 or 2 at `fifo_stat[2k+1:2k]`.
- R5: A capture into a full channel discards the oldest entry and stores the new value. The fill level stays at 2.
- R6: The `rd_data` slice `[16k+15:16k]` always shows the oldest entry. A one-cycle `rd_pop[k]` removes that entry. A pop on an empty channel has no effect.
- R7: `irq_flag[k]` is set on every stored capture. A one-cycle `flag_clr[k]` clears it. If a capture and a clear arrive in the same cycle, the flag stays set.
- R8: `irq[k]` is high exactly when `irq_flag[k]` and `irq_mask[k]` are both high.
- R9: Channels are independent. Activity on one channel changes no other channel's data, fill level or flag.
- R10: After reset, every fill level, flag and interrupt is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbase | input | 16 | Free-running timebase value |
| cap_pin | input | 3 | Asynchronous capture pins, one per channel |
| edge_sel | input | 6 | Edge select, 2 bits per channel |
| irq_mask | input | 3 | Interrupt enable per channel |
| flag_clr | input | 3 | Write-1 clear strobe for the flags |
| rd_pop | input | 3 | Pop strobe per channel |
| rd_data | output | 48 | Oldest entry per channel, 16 bits each |
| fifo_stat | output | 6 | Fill level per channel, 2 bits each |
| irq_flag | output | 3 | Capture event flag per channel |
| irq | output | 3 | Masked interrupt per channel |

## Verification
Errors in the internal state show up at the ports within a few cycles.

- A wrong fill counter appears on `fifo_stat` on the cycle after the push or pop that caused it.
- Misordered storage appears on `rd_data` at the next read, or at the second read when an overflow has happened.
- A qualifier that accepts short glitches shows up as an unexpected fill-level change roughly three cycles after a one-cycle pulse.
- A qualifier that is too strict shows up as a missing capture after a two-cycle pulse.

The bench drives a known timebase value during each capture window. It can therefore compare every popped word against a scoreboard queue that is modelled on the overflow rule.

// File: rtl/ecu_pkg.sv
package ecu_pkg;

  typedef enum logic [1:0] {
    SEL_OFF  = 2'b00,
    SEL_RISE = 2'b01,
    SEL_FALL = 2'b10,
    SEL_BOTH = 2'b11
  } edge_sel_e;

  // Returns 1 when a qualified transition matches the channel's edge select.
  function automatic logic edge_hit(input logic [1:0] sel,
                                    input logic       rise,
                                    input logic       fall);
    return (rise && sel[0]) || (fall && sel[1]);
  endfunction

  // Fill level after one cycle. Overflow drops one entry before the push.
  function automatic int unsigned next_level(input int unsigned lvl,
                                             input int unsigned depth,
                                             input logic        push,
                                             input logic        pop);
    int unsigned n;
    n = lvl;
    if ((pop && lvl != 0) || (push && lvl == depth)) n = n - 1;
    if (push) n = n + 1;
    return n;
  endfunction

endpackage

// File: rtl/ecu_qualifier.sv
module ecu_qualifier (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic s1, s2, s3, qlvl;
  logic accept;

  // A new level is accepted when it is seen on two consecutive sampled edges.
  assign accept = (s2 == s3) && (s2 != qlvl);
  assign rise   = accept && s2;
  assign fall   = accept && !s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      s3   <= 1'b0;
      qlvl <= 1'b0;
    end else begin
      s1 <= pin;
      s2 <= s1;
      s3 <= s2;
      if (accept) qlvl <= s2;
    end
  end

  // R1: a qualified edge needs two stable samples, so two edges are never adjacent
  a_r1_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (rise || fall) |=> !(rise || fall));

endmodule

// File: rtl/ecu_fifo.sv
module ecu_fifo #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 2,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] level
);
  logic [DW-1:0] mem  [DEPTH];
  logic [DW-1:0] nmem [DEPTH];
  logic [CW-1:0] cnt, ncnt;
  logic          full, pop_ok, shift;

  assign full   = (cnt == CW'(DEPTH));
  assign pop_ok = pop && (cnt != '0);
  assign shift  = pop_ok || (push && full);
  assign head   = mem[0];
  assign level  = cnt;

  always_comb begin
    logic [CW-1:0] base;
    for (int i = 0; i < DEPTH; i++) nmem[i] = mem[i];
    if (shift)
      for (int i = 0; i < DEPTH - 1; i++) nmem[i] = mem[i+1];
    base = shift ? cnt - CW'(1) : cnt;
    if (push)
      for (int i = 0; i < DEPTH; i++)
        if (base == CW'(i)) nmem[i] = din;
    ncnt = CW'(ecu_pkg::next_level(int'(cnt), DEPTH, push, pop));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      cnt <= ncnt;
      for (int i = 0; i < DEPTH; i++) mem[i] <= nmem[i];
    end
  end

  // R4: the fill level never exceeds the depth
  a_r4_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R5: a push into a full FIFO keeps it full
  a_r5_overflow_full: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> (cnt == CW'(DEPTH)));
  // R6: a pop without a push lowers the level by one
  a_r6_pop_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && !push) |=> (cnt == $past(cnt) - CW'(1)));
  // R6: a pop on an empty FIFO leaves it empty
  a_r6_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && cnt == '0) |=> (cnt == '0));

endmodule

// File: rtl/ecu_channel.sv
module ecu_channel #(
  parameter int unsigned TW    = 16,
  parameter int unsigned DEPTH = 2,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] tbase,
  input  logic          pin,
  input  logic [1:0]    sel,
  input  logic          mask,
  input  logic          clr,
  input  logic          pop,
  output logic [TW-1:0] data,
  output logic [CW-1:0] level,
  output logic          flag,
  output logic          irq
);
  logic q_rise, q_fall, hit;

  ecu_qualifier u_qual (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (pin),
    .rise (q_rise),
    .fall (q_fall)
  );

  assign hit = ecu_pkg::edge_hit(sel, q_rise, q_fall);

  ecu_fifo #(.DW(TW), .DEPTH(DEPTH)) u_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .push (hit),
    .din  (tbase),
    .pop  (pop),
    .head (data),
    .level(level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assign irq = flag & mask;

  // R7: the flag only rises after a stored capture
  a_r7_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(hit));
  // R2: with selection off no capture is stored
  a_r2_off_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == ecu_pkg::SEL_OFF) |-> !hit);

endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit #(
  parameter int unsigned NCH   = 3,
  parameter int unsigned TW    = 16,
  parameter int unsigned DEPTH = 2,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     tbase,
  input  logic [NCH-1:0]    cap_pin,
  input  logic [2*NCH-1:0]  edge_sel,
  input  logic [NCH-1:0]    irq_mask,
  input  logic [NCH-1:0]    flag_clr,
  input  logic [NCH-1:0]    rd_pop,
  output logic [NCH*TW-1:0] rd_data,
  output logic [CW*NCH-1:0] fifo_stat,
  output logic [NCH-1:0]    irq_flag,
  output logic [NCH-1:0]    irq
);
  for (genvar k = 0; k < NCH; k++) begin : g_ch
    ecu_channel #(.TW(TW), .DEPTH(DEPTH)) u_ch (
      .clk  (clk),
      .rst_n(rst_n),
      .tbase(tbase),
      .pin  (cap_pin[k]),
      .sel  (edge_sel[2*k +: 2]),
      .mask (irq_mask[k]),
      .clr  (flag_clr[k]),
      .pop  (rd_pop[k]),
      .data (rd_data[k*TW +: TW]),
      .level(fifo_stat[k*CW +: CW]),
      .flag (irq_flag[k]),
      .irq  (irq[k])
    );
  end

  // R8: an interrupt is never raised on a masked channel
  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~irq_mask) == '0);

endmodule

// File: tb/sim_edge_capture_unit.sv
module sim_edge_capture_unit;
  localparam int PER = 10;

  logic        clk = 0, rst_n = 0;
  logic [15:0] tbase = 0;
  logic [2:0]  cap_pin = 0, irq_mask = 0, flag_clr = 0, rd_pop = 0;
  logic [5:0]  edge_sel = 0;
  logic [47:0] rd_data;
  logic [5:0]  fifo_stat;
  logic [2:0]  irq_flag, irq;

  int checks = 0, fails = 0;
  logic [15:0] sb [3][$];
  logic [2:0]  exp_flag = 0;

  edge_capture_unit u0 (
    .clk(clk), .rst_n(rst_n), .tbase(tbase), .cap_pin(cap_pin),
    .edge_sel(edge_sel), .irq_mask(irq_mask), .flag_clr(flag_clr),
    .rd_pop(rd_pop), .rd_data(rd_data), .fifo_stat(fifo_stat),
    .irq_flag(irq_flag), .irq(irq)
  );

  always #(PER/2) clk = ~clk;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: expect a capture of value v on channel k (R5 overflow model)
  task automatic expect_cap(input int k, input logic [15:0] v);
    if (sb[k].size() == 2) void'(sb[k].pop_front());
    sb[k].push_back(v);
    exp_flag[k] = 1'b1;
  endtask

  // Monitor: compare the status, flags and interrupts of all channels
  task automatic check_state(input string tag);
    for (int k = 0; k < 3; k++) begin
      chk(fifo_stat[2*k +: 2] == 2'(sb[k].size()), {tag, " R4 R9 level"},
          fifo_stat[2*k +: 2], sb[k].size());
      chk(irq_flag[k] == exp_flag[k], {tag, " R7 flag"}, irq_flag[k], exp_flag[k]);
      chk(irq[k] == (exp_flag[k] & irq_mask[k]), {tag, " R8 irq"}, irq[k],
          exp_flag[k] & irq_mask[k]);
    end
  endtask

  // Pop one entry and compare it with the scoreboard (R6)
  task automatic read_ch(input int k);
    logic [15:0] e;
    if (sb[k].size() != 0) begin
      e = sb[k].pop_front();
      chk(rd_data[16*k +: 16] == e, "R6 R3 read data", rd_data[16*k +: 16], e);
    end
    rd_pop[k] = 1'b1;
    cyc(1);
    rd_pop[k] = 1'b0;
  endtask

  task automatic set_pin(input int k, input logic v, input logic [15:0] t);
    tbase = t;
    cap_pin[k] = v;
    cyc(6);
  endtask

  initial begin
    #(PER * 150000);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    edge_sel = {2'b11, 2'b10, 2'b01};
    irq_mask = 3'b011;
    cyc(3);
    check_state("R10 reset");
    rst_n = 1;
    cyc(2);

    // R2 rising-only on channel 0, R3 stored value
    set_pin(0, 1, 16'h1111); expect_cap(0, 16'h1111); check_state("R2 rise");
    set_pin(0, 0, 16'h9999); check_state("R2 fall ignored");
    set_pin(0, 1, 16'h2222); expect_cap(0, 16'h2222); check_state("R4 two");
    set_pin(0, 0, 16'h0);
    set_pin(0, 1, 16'h3333); expect_cap(0, 16'h3333); check_state("R5 overflow");
    read_ch(0); check_state("R6 pop1");
    read_ch(0); check_state("R6 pop2");
    read_ch(0); check_state("R6 empty pop");

    // R7 write-1 clear
    flag_clr = 3'b001; cyc(1); flag_clr = 0; exp_flag[0] = 0;
    check_state("R7 clear");

    // R2 falling-only on channel 1
    set_pin(1, 1, 16'hAAAA); check_state("R2 rise ignored");
    set_pin(1, 0, 16'hBBBB); expect_cap(1, 16'hBBBB); check_state("R2 fall");
    set_pin(1, 1, 16'h0);

    // R1 one-cycle low glitch ignored, two-cycle pulse accepted
    tbase = 16'hC0DE;
    cap_pin[1] = 0; cyc(1); cap_pin[1] = 1; cyc(6);
    check_state("R1 glitch");
    tbase = 16'hD00D;
    cap_pin[1] = 0; cyc(2); cap_pin[1] = 1; cyc(6);
    expect_cap(1, 16'hD00D);
    check_state("R1 two cycle");

    // R2 both edges on channel 2, R8 masked
    set_pin(2, 1, 16'h4444); expect_cap(2, 16'h4444);
    set_pin(2, 0, 16'h5555); expect_cap(2, 16'h5555);
    check_state("R8 masked both");
    irq_mask = 3'b111; cyc(1); check_state("R8 unmasked");
    read_ch(2); read_ch(2); check_state("R9 ch2 drained");
    read_ch(1); read_ch(1); check_state("R9 ch1 drained");

    // R2 selection off
    edge_sel[1:0] = 2'b00;
    set_pin(0, 1, 16'h7777); set_pin(0, 0, 16'h8888);
    check_state("R2 off");

    // R7 capture and clear together: flag stays set
    edge_sel[5:4] = 2'b11;
    tbase = 16'h6666;
    cap_pin[2] = 1; cyc(3);
    flag_clr[2] = 1;
    cyc(1); flag_clr[2] = 0; cyc(4);
    expect_cap(2, 16'h6666);
    check_state("R7 set wins");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule